// File: doc/BRIEF.md
# Time-Slot Interchange Switch

This block switches 8-bit channels among eight serial time-division streams. A frame of each stream has 32 channels. Each channel is eight consecutive bit periods, most significant bit first, and one clock cycle is one bit period. A frame-sync pulse marks the first bit of channel 0. Every incoming channel is assembled into a byte and stored in a two-bank data memory. One bank collects the current frame while the other holds the frame just finished.

A connection memory has one entry for each output slot (stream, channel). A host loads it. An entry selects one of two sources for the slot. In switched mode the slot carries a stored input byte. In message mode it carries a constant byte held in the entry itself. The entry also decides whether the slot is driven at all. Each output stream has a data bit and a separate drive-enable bit, which stand in for a three-state pad. The host can also read back any byte from the last completed input frame.

Top module: `tsi_switch`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every `st_oe` and `st_out` bit is 0. Every connection entry reads back as 0 after reset.
- R2: A cycle with `frame_sync` high is bit 0 of channel 0. Channel c, bit b falls at frame position 8·c+b, MSB first, on both the inputs and the outputs. A switched entry pointing at its own stream and channel reproduces the input byte one frame later.
- R3: In switched mode (entry bit 9 = 1, bit 8 = 0), the output slot carries the byte that arrived in the previous frame on the input named by entry bits 7:5 (stream) and 4:0 (channel), and `st_oe` is high for all eight bits of the slot.
- R4: One input channel may feed any number of output slots in the same frame, and all of them carry the same byte.
- R5: In message mode (bit 9 = 1, bit 8 = 1), the slot carries entry bits 7:0 in every frame, whatever the inputs do.
- R6: With bit 9 = 0, the slot has `st_oe` low and `st_out` 0 for all eight bits. Neighbouring slots are not affected.
- R7: `st_out[s]` is 0 whenever `st_oe[s]` is 0.
- R8: A write with `host_sel`=0 stores `host_wdata` into the entry at `host_addr` = {stream[2:0], channel[4:0]}. A read with `host_sel`=0 returns that entry on `host_rdata` one cycle later.
- R9: A read with `host_sel`=1 returns {2'b00, byte} one cycle later, where byte is the one received at `host_addr` during the last completed frame.
- R10: A write with `host_sel`=1 has no effect on the stored input data.
- R11: Output channel 0 may be sourced from input channel 31 of the previous frame, including the channel that finishes in the cycle just before channel 0 starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one cycle per bit period |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | High in the cycle of bit 0, channel 0 |
| st_in | input | 8 | One serial input bit per stream |
| st_out | output | 8 | One serial output bit per stream |
| st_oe | output | 8 | Drive enable per output stream, per slot |
| host_sel | input | 1 | 0 selects the connection memory, 1 selects the input data |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | {stream, channel} slot address |
| host_wdata | input | 10 | Entry: [9] enable, [8] message, [7:0] source or byte |
| host_rdata | output | 10 | Registered read data |

## Verification
The assertions assume that `frame_sync` only arrives every 256 cycles, exactly where the free-running position would wrap. Under that assumption the bank swap always falls after position 255, and an output enable can only change at a channel boundary. The bench pulses `frame_sync` at every frame start. It changes connection entries only while output checking is paused, and it resumes checking only after a full frame has gone by, so every prefetched entry matches its model. Host data reads are issued in the middle of a frame, so the bank being read cannot swap between the request and the sample.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int NSTR  = 8;
    localparam int NCH   = 32;
    localparam int BW    = 8;
    localparam int STR_W = $clog2(NSTR);
    localparam int CH_W  = $clog2(NCH);
    localparam int BIT_W = $clog2(BW);
    localparam int ADDR_W = STR_W + CH_W;
    localparam int POS_W  = CH_W + BIT_W;
    localparam int NSLOT  = NSTR * NCH;

    typedef logic [ADDR_W-1:0] slot_t;
    typedef logic [BW-1:0]     byte_t;
    typedef logic [POS_W-1:0]  pos_t;

    // one output slot: drive enable, message select, source slot or message byte
    typedef struct packed {
        logic  oe;
        logic  msg;
        byte_t sel;
    } conn_t;

    localparam int HOST_W = $bits(conn_t);
    localparam pos_t LAST_POS = '1;

    function automatic slot_t make_slot(logic [STR_W-1:0] s, logic [CH_W-1:0] c);
        return {s, c};
    endfunction

    function automatic logic [CH_W-1:0] pos_chan(pos_t p);
        return p[POS_W-1:BIT_W];
    endfunction

    function automatic logic [BIT_W-1:0] pos_bit(pos_t p);
        return p[BIT_W-1:0];
    endfunction
endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase
    import tsi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_sync,
    output pos_t pos,
    output logic bank
);
    pos_t cnt_q;

    assign pos = frame_sync ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            bank  <= 1'b0;
        end else begin
            cnt_q <= pos + pos_t'(1);
            if (pos == LAST_POS)
                bank <= ~bank;
        end
    end

    // R2: banks swap exactly after the last bit of a frame
    a_r2_bank_flip: assert property (@(posedge clk) disable iff (rst)
        (pos == LAST_POS) |=> (bank != $past(bank)));
    a_r2_bank_hold: assert property (@(posedge clk) disable iff (rst)
        (pos != LAST_POS) |=> $stable(bank));
endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane
    import tsi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output byte_t byte_o
);
    byte_t sh_q;

    // byte completed by the bit arriving this cycle
    assign byte_o = {sh_q[BW-2:0], din};

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else
            sh_q <= {sh_q[BW-2:0], din};
    end
endmodule

// File: rtl/tsi_data_store.sv
module tsi_data_store
    import tsi_pkg::*;
(
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic                       wr_bank,
    input  logic [CH_W-1:0]            wr_chan,
    input  logic [NSTR-1:0][BW-1:0]    wr_bytes,
    input  logic                       rd_bank,
    input  logic [NSTR-1:0][ADDR_W-1:0] rd_addr,
    output logic [NSTR-1:0][BW-1:0]    rd_data,
    input  logic                       host_bank,
    input  slot_t                      host_addr,
    output byte_t                      host_data
);
    byte_t mem [0:1][0:NSLOT-1];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int s = 0; s < NSTR; s++)
                mem[wr_bank][make_slot(STR_W'(s), wr_chan)] <= wr_bytes[s];
        end
    end

    for (genvar p = 0; p < NSTR; p++) begin : g_rd
        logic fwd;
        assign fwd = wr_en && (rd_bank == wr_bank) &&
                     (rd_addr[p][CH_W-1:0] == wr_chan);
        assign rd_data[p] = fwd ? wr_bytes[rd_addr[p][ADDR_W-1:CH_W]]
                                : mem[rd_bank][rd_addr[p]];
    end

    assign host_data = mem[host_bank][host_addr];
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane
    import tsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BIT_W-1:0] bit_idx,
    input  conn_t            entry,
    input  byte_t            src_byte,
    output logic             dout,
    output logic             oe_o
);
    byte_t sh_q;
    logic  load;

    assign load = (bit_idx == BIT_W'(BW - 1));
    assign dout = sh_q[BW-1] & oe_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            oe_o <= 1'b0;
        end else if (load) begin
            sh_q <= entry.msg ? entry.sel : src_byte;
            oe_o <= entry.oe;
        end else begin
            sh_q <= {sh_q[BW-2:0], 1'b0};
        end
    end

    // R6: the enable is held across all bits of one slot
    a_r6_oe_slot_steady: assert property (@(posedge clk) disable iff (rst)
        (bit_idx != '0) |-> $stable(oe_o));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync,
    input  logic [NSTR-1:0]   st_in,
    output logic [NSTR-1:0]   st_out,
    output logic [NSTR-1:0]   st_oe,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata
);
    pos_t                        pos;
    logic                        bank;
    logic [NSTR-1:0][BW-1:0]     rx_bytes;
    logic [NSTR-1:0][ADDR_W-1:0] rd_addr;
    logic [NSTR-1:0][BW-1:0]     rd_data;
    conn_t                       entry [NSTR];
    conn_t                       cm [NSLOT];
    byte_t                       host_dm;
    logic [CH_W-1:0]             nxt_chan;
    logic                        rd_bank;
    logic                        wr_en;

    tsi_timebase u_tb (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .pos        (pos),
        .bank       (bank)
    );

    assign wr_en    = (pos_bit(pos) == BIT_W'(BW - 1));
    assign nxt_chan = pos_chan(pos) + CH_W'(1);
    // the prefetch for channel 0 reads the bank that is finishing now
    assign rd_bank  = (pos == LAST_POS) ? bank : ~bank;

    for (genvar s = 0; s < NSTR; s++) begin : g_lane
        tsi_rx_lane u_rx (
            .clk    (clk),
            .rst    (rst),
            .din    (st_in[s]),
            .byte_o (rx_bytes[s])
        );

        assign entry[s]   = cm[make_slot(STR_W'(s), nxt_chan)];
        assign rd_addr[s] = entry[s].sel[ADDR_W-1:0];

        tsi_tx_lane u_tx (
            .clk      (clk),
            .rst      (rst),
            .bit_idx  (pos_bit(pos)),
            .entry    (entry[s]),
            .src_byte (rd_data[s]),
            .dout     (st_out[s]),
            .oe_o     (st_oe[s])
        );
    end

    tsi_data_store u_ds (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_bank   (bank),
        .wr_chan   (pos_chan(pos)),
        .wr_bytes  (rx_bytes),
        .rd_bank   (rd_bank),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .host_bank (~bank),
        .host_addr (host_addr),
        .host_data (host_dm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++)
                cm[i] <= '0;
            host_rdata <= '0;
        end else begin
            if (host_we && !host_sel)
                cm[host_addr] <= conn_t'(host_wdata);
            host_rdata <= host_sel ? HOST_W'(host_dm) : HOST_W'(cm[host_addr]);
        end
    end

    // R1: nothing is driven right after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_oe == '0));
    // R9: data-memory reads are zero-padded above the byte
    a_r9_data_read_pad: assert property (@(posedge clk) disable iff (rst)
        ($past(host_sel) && !$past(rst)) |-> (host_rdata[HOST_W-1:BW] == '0));
endmodule

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_sync = 1'b0;
    logic [7:0] st_in = '0;
    logic [7:0] st_out, st_oe;
    logic       host_sel = 1'b0, host_we = 1'b0;
    logic [7:0] host_addr = '0;
    logic [9:0] host_wdata = '0;
    logic [9:0] host_rdata;

    int n_chk = 0, n_bad = 0;
    int bpos = 0, frame_no = -1;
    bit go = 0, check_en = 0;
    string cur_tag = "R3";
    logic [9:0] cm_model [256];
    logic [7:0] acc [8];
    logic oe_all [8], oe_any [8], r7bad [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    tsi_switch u0 (
        .clk(clk), .rst(rst), .frame_sync(frame_sync), .st_in(st_in),
        .st_out(st_out), .st_oe(st_oe), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    function automatic logic [7:0] in_byte(int f, int s, int c);
        return 8'((f * 53) ^ (s * 29) ^ (c * 7) ^ 8'h5A);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // stream driver and output checker
    initial begin : streams
        int p, b, c;
        logic [7:0] v, eb;
        logic [9:0] e;
        string tg;
        bit ok;
        wait (go);
        forever begin
            p = bpos; b = p % 8; c = p / 8;
            if (p == 0) frame_no++;
            if (check_en) begin
                for (int s = 0; s < 8; s++) begin
                    if (b == 0) begin
                        acc[s] = '0; oe_all[s] = 1'b1; oe_any[s] = 1'b0; r7bad[s] = 1'b0;
                    end
                    acc[s] = {acc[s][6:0], st_out[s]};
                    oe_all[s] &= st_oe[s];
                    oe_any[s] |= st_oe[s];
                    if (!st_oe[s] && st_out[s]) r7bad[s] = 1'b1;
                    if (b == 7) begin
                        e = cm_model[s*32 + c];
                        if (!e[9]) begin
                            tg = "R6"; eb = 8'h00; ok = !oe_any[s];
                        end else begin
                            eb = e[8] ? e[7:0] : in_byte(frame_no - 1, int'(e[7:5]), int'(e[4:0]));
                            tg = e[8] ? "R5" : ((c == 0 && e[4:0] == 5'd31) ? "R11" : cur_tag);
                            ok = oe_all[s];
                        end
                        n_chk++;
                        if (!ok || acc[s] !== eb) begin
                            n_bad++;
                            $display("FAIL %s lane %0d ch %0d frame %0d: actual %h oe_all=%0b oe_any=%0b expected %h oe=%0b",
                                     tg, s, c, frame_no, acc[s], oe_all[s], oe_any[s], eb, e[9]);
                        end
                        n_chk++;
                        if (r7bad[s]) begin
                            n_bad++;
                            $display("FAIL R7 lane %0d ch %0d: actual data 1 while disabled expected 0", s, c);
                        end
                    end
                end
            end
            frame_sync = (p == 0);
            for (int s = 0; s < 8; s++) begin
                v = in_byte(frame_no, s, c);
                st_in[s] = v[7 - b];
            end
            bpos = (p + 1) % 256;
            @(negedge clk);
        end
    end

    task automatic host_write(logic sel, logic [7:0] a, logic [9:0] d);
        @(negedge clk);
        host_sel = sel; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        if (!sel) cm_model[a] = d;
    endtask

    task automatic host_read(logic sel, logic [7:0] a, output logic [9:0] d);
        @(negedge clk);
        host_sel = sel; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic wait_frame();
        do @(posedge clk); while (bpos != 0);
    endtask

    task automatic run_checked(int frames);
        wait_frame(); wait_frame();
        check_en = 1;
        for (int i = 0; i < frames; i++) wait_frame();
        check_en = 0;
    endtask

    task automatic t_reset();
        logic [9:0] d;
        repeat (3) @(negedge clk);
        check("R1", st_oe, 8'h00, "st_oe in reset");
        check("R1", st_out, 8'h00, "st_out in reset");
        rst = 1'b0; go = 1;
        @(negedge clk);
        check("R1", st_oe, 8'h00, "st_oe after reset");
        host_read(1'b0, 8'h00, d);
        check("R1", d, 10'h000, "entry 0 after reset");
        host_read(1'b0, 8'hFF, d);
        check("R1", d, 10'h000, "entry 255 after reset");
    endtask

    task automatic t_host_cm();
        logic [9:0] d;
        host_write(1'b0, 8'h45, 10'h2A7);
        host_write(1'b0, 8'h46, 10'h155);
        host_read(1'b0, 8'h45, d);
        check("R8", d, 10'h2A7, "entry 0x45 readback");
        host_read(1'b0, 8'h46, d);
        check("R8", d, 10'h155, "entry 0x46 readback");
    endtask

    task automatic t_identity();
        for (int a = 0; a < 256; a++) host_write(1'b0, 8'(a), {2'b10, 8'(a)});
        cur_tag = "R2";
        run_checked(2);
    endtask

    task automatic t_crossmap();
        for (int s = 0; s < 8; s++)
            for (int c = 0; c < 32; c++)
                host_write(1'b0, 8'(s*32 + c), {2'b10, 3'((s + 3) % 8), 5'(31 - c)});
        cur_tag = "R3";
        run_checked(2);
    endtask

    task automatic t_broadcast();
        for (int a = 0; a < 256; a++) host_write(1'b0, 8'(a), {2'b10, 3'd2, 5'd5});
        cur_tag = "R4";
        run_checked(2);
    endtask

    task automatic t_mixed();
        for (int s = 0; s < 8; s++)
            for (int c = 0; c < 32; c++) begin
                if (c % 3 == 0)      host_write(1'b0, 8'(s*32 + c), {2'b11, 8'(c*9 + s)});
                else if (c % 3 == 1) host_write(1'b0, 8'(s*32 + c), {2'b01, 8'hFF});
                else                 host_write(1'b0, 8'(s*32 + c), {2'b10, 3'(7 - s), 5'(c)});
            end
        cur_tag = "R3";
        run_checked(2);
    endtask

    task automatic t_host_data();
        logic [9:0] d;
        int f;
        do @(posedge clk); while (bpos < 16 || bpos > 180);
        f = frame_no;
        host_read(1'b1, 8'h00, d);
        check("R9", d, {2'b00, in_byte(f - 1, 0, 0)}, "data s0 c0");
        host_read(1'b1, 8'hFF, d);
        check("R9", d, {2'b00, in_byte(f - 1, 7, 31)}, "data s7 c31");
        host_read(1'b1, 8'h6A, d);
        check("R9", d, {2'b00, in_byte(f - 1, 3, 10)}, "data s3 c10");
        host_write(1'b1, 8'h6A, 10'h0C3);
        host_read(1'b1, 8'h6A, d);
        check("R10", d, {2'b00, in_byte(f - 1, 3, 10)}, "data after ignored write");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        for (int a = 0; a < 256; a++) cm_model[a] = '0;
        t_reset();
        t_host_cm();
        t_identity();
        t_crossmap();
        t_broadcast();
        t_mixed();
        t_host_data();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule